// File: doc/BRIEF.md
# Lagging Thread Selector With Utility

This block keeps a retired-instruction count for every hardware thread in a cluster. When the quantum tick arrives it decides which threads have fallen behind the slowest active thread, gives each of them an acceleration score, and names the thread that would gain the most from a move to the big core. A thread counts as active for a quantum when its reported busy-cycle count is non-zero. The slowest active count sets a floor. Every active thread whose count lies below that floor plus a fixed margin joins the lagging group.

Each lagging thread is scored as the product of three unsigned Q0.16 fractions. The local gain is one minus the reciprocal of its predicted big-core speedup, which arrives in Q8.8. The relevance is its busy cycles divided by the quantum length, where the quantum is a power of two. The global share is the reciprocal of the lagging group's size. One shared serial divider supplies both reciprocals. The winner, its score and the lagging group are posted together with a one-cycle strobe. The counters clear on a barrier pulse, so comparisons stay inside one barrier interval.

Top module: `lag_util_select`

## Requirements
- R1: Each thread's progress counter adds one for every cycle its commit input is high, and holds at 2^PCW-1 instead of wrapping.
- R2: A barrier pulse clears every progress counter. A commit in the same cycle as the barrier is discarded.
- R3: At an accepted tick a thread is active when its busy-cycle input is non-zero. minP is the smallest progress among active threads. Lagging-mask bit i (bit i = thread i) is set when thread i is active and its progress is strictly less than minP + DELTA_P.
- R4: The global factor is 65536/N truncated, where N is the number of lagging threads, and it saturates to 0xFFFF when N is 1.
- R5: The local factor is 65536 - floor(2^24/S) for speedup S in Q8.8, and it is 0 whenever S <= 256 (1.0), including S = 0.
- R6: The relevance factor is the busy cycles times 2^(16-QLOG2), saturated to 0xFFFF.
- R7: Utility = floor(floor(L*R/65536)*G/65536), 16 bits.
- R8: The selected ID is the lagging thread with the largest utility. Equal utilities go to the lowest ID.
- R9: The result strobe is high for exactly one cycle per evaluation. Mask, ID and utility change only with the strobe and hold until the next one. No strobe is raised when the lagging group is empty.
- R10: Speedups, busy cycles and progress are captured at the accepted tick. A tick that arrives while an evaluation is running is ignored, and input changes during the run do not alter its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| i_commit | input | NTHR | Per-thread retire pulse |
| i_speedup | input | NTHR x 16 | Per-thread predicted speedup, Q8.8 |
| i_active_cyc | input | NTHR x ACW | Per-thread busy cycles in the last quantum |
| i_barrier | input | 1 | Clears all progress counters |
| i_quantum_tick | input | 1 | Starts an evaluation |
| o_lag_mask | output | NTHR | Lagging group of the last evaluation |
| o_sel_id | output | IDW | Chosen thread |
| o_utility | output | 16 | Utility of the chosen thread, Q0.16 |
| o_valid | output | 1 | One-cycle result strobe |

## Verification
A progress counter that drifts, wraps or misses a clear moves the floor or the margin test, so the next posted mask shows a thread set or cleared wrongly. A bad quotient or product from the divider shows up as a utility that is off by the full factor, or as a different winner, at the next strobe. FSM or snapshot faults appear as a strobe that is missing, doubled or late, or as a result built from inputs that changed after the tick. The bench therefore compares every posted mask, ID and utility against values computed arithmetically, and it watches the strobe for a window after each evaluation.

// File: rtl/lag_util_pkg.sv
package lag_util_pkg;

  localparam int FXW = 16;   // Q0.16 factor width
  localparam int SPW = 16;   // Q8.8 speedup width
  localparam int RDW = 25;   // reciprocal dividend width (2^24 fits)

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GSTART,
    ST_GWAIT,
    ST_LSTART,
    ST_LWAIT,
    ST_DONE
  } sel_state_e;

  // 1 - 1/S given recip = floor(2^24 / S)
  function automatic logic [FXW-1:0] loc_factor(input logic [RDW-1:0] recip);
    if (recip >= RDW'(65536)) return '0;
    return FXW'(RDW'(65536) - recip);
  endfunction

  // 1/N given recip = floor(65536 / N), saturated
  function automatic logic [FXW-1:0] glob_factor(input logic [RDW-1:0] recip);
    if (recip >= RDW'(65536)) return '1;
    return recip[FXW-1:0];
  endfunction

  // active / 2^qlog2 in Q0.16, saturated
  function automatic logic [FXW-1:0] rel_factor(input logic [31:0] act, input int qlog2);
    logic [47:0] sc;
    sc = {16'd0, act} << (16 - qlog2);
    if (sc > 48'hFFFF) return '1;
    return sc[FXW-1:0];
  endfunction

  // L*R*G with truncation after each product
  function automatic logic [FXW-1:0] util_prod(input logic [FXW-1:0] l,
                                               input logic [FXW-1:0] r,
                                               input logic [FXW-1:0] g);
    logic [31:0] lr;
    logic [31:0] lrg;
    lr  = 32'(l) * 32'(r);
    lrg = 32'(lr[31:16]) * 32'(g);
    return lrg[31:16];
  endfunction

endpackage

// File: rtl/lag_progress_track.sv
module lag_progress_track #(
  parameter int NTHR    = 8,
  parameter int PCW     = 16,
  parameter int ACW     = 16,
  parameter int DELTA_P = 16,
  localparam int CNTW   = $clog2(NTHR + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NTHR-1:0]           i_commit,
  input  logic                      i_barrier,
  input  logic [NTHR-1:0][ACW-1:0]  i_active_cyc,
  output logic [NTHR-1:0]           o_lag_mask,
  output logic [CNTW-1:0]           o_lag_cnt
);

  localparam int SW = PCW + 2;

  logic [PCW-1:0]  prog [NTHR];
  logic [NTHR-1:0] act_on;
  logic [PCW-1:0]  min_p;
  logic [SW-1:0]   lag_limit;

  for (genvar t = 0; t < NTHR; t++) begin : g_thr
    assign act_on[t] = |i_active_cyc[t];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              prog[t] <= '0;
      else if (i_barrier)                      prog[t] <= '0;
      else if (i_commit[t] && (prog[t] != '1)) prog[t] <= prog[t] + 1'b1;
    end

    p_sat_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (prog[t] == '1 && !i_barrier) |=> (prog[t] == '1));

    p_barrier_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
      i_barrier |=> (prog[t] == '0));

    p_min_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      act_on[t] |-> (prog[t] >= min_p));
  end

  always_comb begin
    min_p = '1;
    for (int t = 0; t < NTHR; t++) begin
      if (act_on[t] && (prog[t] < min_p)) min_p = prog[t];
    end
  end

  assign lag_limit = SW'(min_p) + SW'(DELTA_P);

  always_comb begin
    o_lag_cnt = '0;
    for (int t = 0; t < NTHR; t++) begin
      o_lag_mask[t] = act_on[t] && (SW'(prog[t]) < lag_limit);
      o_lag_cnt     = o_lag_cnt + CNTW'(o_lag_mask[t]);
    end
  end

  p_lag_active_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (act_on != '0 && DELTA_P > 0) |-> (o_lag_cnt != '0));

endmodule

// File: rtl/lag_recip_div.sv
module lag_recip_div #(
  parameter int DW = 25,
  parameter int VW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          i_start,
  input  logic [DW-1:0] i_dividend,
  input  logic [VW-1:0] i_divisor,
  output logic          o_done,
  output logic [DW-1:0] o_quot
);

  localparam int CW = $clog2(DW + 1);

  logic [VW-1:0] rem;
  logic [DW-1:0] quo;
  logic [DW-1:0] dvd_q;
  logic [VW-1:0] dsr_q;
  logic [CW-1:0] left;
  logic          run;
  logic [VW:0]   trial;
  logic          fits;

  assign trial = {rem, quo[DW-1]};
  assign fits  = (trial >= {1'b0, dsr_q});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem <= '0; quo <= '0; dvd_q <= '0; dsr_q <= '0;
      left <= '0; run <= 1'b0; o_done <= 1'b0;
    end else begin
      o_done <= 1'b0;
      if (i_start) begin
        rem   <= '0;
        quo   <= i_dividend;
        dvd_q <= i_dividend;
        dsr_q <= i_divisor;
        left  <= CW'(DW);
        run   <= 1'b1;
      end else if (run) begin
        rem  <= fits ? VW'(trial - {1'b0, dsr_q}) : VW'(trial);
        quo  <= {quo[DW-2:0], fits};
        left <= left - 1'b1;
        if (left == CW'(1)) begin
          run    <= 1'b0;
          o_done <= 1'b1;
        end
      end
    end
  end

  assign o_quot = quo;

  p_div_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    o_done |=> !o_done);

  p_div_exact_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (o_done && dsr_q != '0) |->
      ((48'(quo) * 48'(dsr_q) <= 48'(dvd_q)) &&
       (48'(dvd_q) - 48'(quo) * 48'(dsr_q) < 48'(dsr_q))));

endmodule

// File: rtl/lag_util_select.sv
module lag_util_select #(
  parameter int NTHR    = 8,
  parameter int PCW     = 16,
  parameter int ACW     = 16,
  parameter int QLOG2   = 10,
  parameter int DELTA_P = 16,
  localparam int IDW    = (NTHR > 1) ? $clog2(NTHR) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NTHR-1:0]          i_commit,
  input  logic [NTHR-1:0][15:0]    i_speedup,
  input  logic [NTHR-1:0][ACW-1:0] i_active_cyc,
  input  logic                     i_barrier,
  input  logic                     i_quantum_tick,
  output logic [NTHR-1:0]          o_lag_mask,
  output logic [IDW-1:0]           o_sel_id,
  output logic [15:0]              o_utility,
  output logic                     o_valid
);

  import lag_util_pkg::*;

  localparam int CNTW = $clog2(NTHR + 1);

  sel_state_e st;

  logic [NTHR-1:0]          trk_mask;
  logic [CNTW-1:0]          trk_cnt;
  logic [NTHR-1:0]          lag_q;
  logic [CNTW-1:0]          cnt_q;
  logic [NTHR-1:0][SPW-1:0] spd_q;
  logic [NTHR-1:0][ACW-1:0] act_q;
  logic [FXW-1:0]           g_q;
  logic [IDW-1:0]           idx_q;
  logic [FXW-1:0]           best_u;
  logic [IDW-1:0]           best_id;
  logic                     have_best;

  logic                     dv_start;
  logic [RDW-1:0]           dv_dividend;
  logic [SPW-1:0]           dv_divisor;
  logic                     dv_done;
  logic [RDW-1:0]           dv_quot;

  logic                     eval_accept;
  logic                     busy;
  logic                     last_idx;
  logic [FXW-1:0]           cand_u;
  logic                     take_best;

  lag_progress_track #(
    .NTHR(NTHR), .PCW(PCW), .ACW(ACW), .DELTA_P(DELTA_P)
  ) u_track (
    .clk         (clk),
    .rst_n       (rst_n),
    .i_commit    (i_commit),
    .i_barrier   (i_barrier),
    .i_active_cyc(i_active_cyc),
    .o_lag_mask  (trk_mask),
    .o_lag_cnt   (trk_cnt)
  );

  lag_recip_div #(.DW(RDW), .VW(SPW)) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .i_start   (dv_start),
    .i_dividend(dv_dividend),
    .i_divisor (dv_divisor),
    .o_done    (dv_done),
    .o_quot    (dv_quot)
  );

  assign eval_accept = (st == ST_IDLE) && i_quantum_tick && (trk_cnt != '0);
  assign busy        = (st != ST_IDLE) && (st != ST_DONE);
  assign last_idx    = (idx_q == IDW'(NTHR - 1));

  always_comb begin
    dv_start    = 1'b0;
    dv_dividend = RDW'(65536);
    dv_divisor  = SPW'(cnt_q);
    if (st == ST_GSTART) begin
      dv_start = 1'b1;
    end else if (st == ST_LSTART) begin
      dv_start    = lag_q[idx_q];
      dv_dividend = RDW'(1) << 24;
      dv_divisor  = spd_q[idx_q];
    end
  end

  assign cand_u    = util_prod(loc_factor(dv_quot),
                               rel_factor(32'(act_q[idx_q]), QLOG2), g_q);
  assign take_best = !have_best || (cand_u > best_u);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE;
      lag_q <= '0; cnt_q <= '0; spd_q <= '0; act_q <= '0;
      g_q <= '0; idx_q <= '0; best_u <= '0; best_id <= '0; have_best <= 1'b0;
      o_lag_mask <= '0; o_sel_id <= '0; o_utility <= '0; o_valid <= 1'b0;
    end else begin
      o_valid <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (eval_accept) begin
            lag_q     <= trk_mask;
            cnt_q     <= trk_cnt;
            spd_q     <= i_speedup;
            act_q     <= i_active_cyc;
            idx_q     <= '0;
            have_best <= 1'b0;
            st        <= ST_GSTART;
          end
        end
        ST_GSTART: st <= ST_GWAIT;
        ST_GWAIT: begin
          if (dv_done) begin
            g_q <= glob_factor(dv_quot);
            st  <= ST_LSTART;
          end
        end
        ST_LSTART: begin
          if (lag_q[idx_q])  st <= ST_LWAIT;
          else if (last_idx) st <= ST_DONE;
          else               idx_q <= idx_q + 1'b1;
        end
        ST_LWAIT: begin
          if (dv_done) begin
            if (take_best) begin
              best_u    <= cand_u;
              best_id   <= idx_q;
              have_best <= 1'b1;
            end
            if (last_idx) st <= ST_DONE;
            else begin
              idx_q <= idx_q + 1'b1;
              st    <= ST_LSTART;
            end
          end
        end
        ST_DONE: begin
          o_valid    <= 1'b1;
          o_lag_mask <= lag_q;
          o_sel_id   <= best_id;
          o_utility  <= best_u;
          st         <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  p_valid_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    o_valid |=> !o_valid);

  p_hold_outputs_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !o_valid |-> ($stable(o_sel_id) && $stable(o_utility) && $stable(o_lag_mask)));

  p_sel_in_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    o_valid |-> o_lag_mask[o_sel_id]);

  p_busy_tick_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && i_quantum_tick) |=> ($stable(lag_q) && $stable(spd_q) && $stable(act_q)));

  p_best_is_lagging_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DONE) |-> (have_best && lag_q[best_id]));

endmodule

// File: tb/lag_util_select_bench.sv
`timescale 1ns/1ps
module lag_util_select_bench;

  localparam int NT = 4;
  localparam int PW = 8;
  localparam int AW = 8;
  localparam int QL = 4;
  localparam int DP = 4;
  localparam int PMAX = 255;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NT-1:0] i_commit = '0;
  logic [NT-1:0][15:0] i_speedup = '0;
  logic [NT-1:0][AW-1:0] i_active_cyc = '0;
  logic i_barrier = 1'b0;
  logic i_quantum_tick = 1'b0;
  logic [NT-1:0] o_lag_mask;
  logic [1:0] o_sel_id;
  logic [15:0] o_utility;
  logic o_valid;

  always #2.5 clk = ~clk;

  lag_util_select #(.NTHR(NT), .PCW(PW), .ACW(AW), .QLOG2(QL), .DELTA_P(DP)) u_lag_util_select (
    .clk(clk), .rst_n(rst_n), .i_commit(i_commit), .i_speedup(i_speedup),
    .i_active_cyc(i_active_cyc), .i_barrier(i_barrier), .i_quantum_tick(i_quantum_tick),
    .o_lag_mask(o_lag_mask), .o_sel_id(o_sel_id), .o_utility(o_utility), .o_valid(o_valid)
  );

  int errors = 0;
  int checks = 0;
  int mprog [NT];
  int spd_v [NT];
  int act_v [NT];
  int cmt_n [NT];
  bit exp_valid;
  int exp_mask, exp_sel, exp_util;
  logic [15:0] lf = 16'hACE1;

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, got, exp);
    end
  endtask

  function automatic logic [15:0] step(input logic [15:0] x);
    return x[0] ? ((x >> 1) ^ 16'hB400) : (x >> 1);
  endfunction

  task automatic commits();
    int mx = 0;
    for (int t = 0; t < NT; t++) if (cmt_n[t] > mx) mx = cmt_n[t];
    for (int k = 0; k < mx; k++) begin
      @(negedge clk);
      for (int t = 0; t < NT; t++) begin
        i_commit[t] = (k < cmt_n[t]);
        if (k < cmt_n[t] && mprog[t] < PMAX) mprog[t]++;
      end
    end
    @(negedge clk);
    i_commit = '0;
  endtask

  task automatic barrier(input bit with_commit);
    @(negedge clk);
    i_barrier = 1'b1;
    if (with_commit) i_commit = '1;
    for (int t = 0; t < NT; t++) mprog[t] = 0;
    @(negedge clk);
    i_barrier = 1'b0;
    i_commit = '0;
  endtask

  task automatic compute_exp();
    int minp = 1 << 30;
    int cnt = 0;
    int g, best;
    exp_mask = 0; exp_sel = 0; exp_util = 0; best = -1;
    for (int t = 0; t < NT; t++) if (act_v[t] != 0 && mprog[t] < minp) minp = mprog[t];
    for (int t = 0; t < NT; t++)
      if (act_v[t] != 0 && mprog[t] < minp + DP) begin
        exp_mask |= (1 << t);
        cnt++;
      end
    exp_valid = (cnt != 0);
    g = (cnt <= 1) ? 65535 : 65536 / (cnt == 0 ? 1 : cnt);
    for (int t = 0; t < NT; t++)
      if (exp_mask[t]) begin
        longint l, r, u;
        l = (spd_v[t] <= 256) ? 0 : 65536 - (16777216 / spd_v[t]);
        r = (act_v[t] >= 16) ? 65535 : act_v[t] * 4096;
        u = (((l * r) / 65536) * g) / 65536;
        if (u > best) begin
          best = int'(u);
          exp_sel = t;
        end
      end
    if (best >= 0) exp_util = best;
  endtask

  task automatic drive_inputs();
    for (int t = 0; t < NT; t++) begin
      i_speedup[t] = 16'(spd_v[t]);
      i_active_cyc[t] = AW'(act_v[t]);
    end
  endtask

  task automatic await_result(input string tag);
    bit seen = 0;
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      if (o_valid) begin
        if (seen) check({tag, " R9 second strobe"}, 1, 0);
        seen = 1;
        if (exp_valid) begin
          check({tag, " R3 mask"}, int'(o_lag_mask), exp_mask);
          check({tag, " R8 sel"}, int'(o_sel_id), exp_sel);
          check({tag, " R7 util"}, int'(o_utility), exp_util);
        end
      end
    end
    check({tag, " R9 strobe presence"}, int'(seen), int'(exp_valid));
  endtask

  task automatic evaluate(input string tag);
    compute_exp();
    @(negedge clk);
    drive_inputs();
    i_quantum_tick = 1'b1;
    @(negedge clk);
    i_quantum_tick = 1'b0;
    await_result(tag);
  endtask

  task automatic set_all(input int s, input int a);
    for (int t = 0; t < NT; t++) begin
      spd_v[t] = s;
      act_v[t] = a;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int t = 0; t < NT; t++) begin
      mprog[t] = 0; spd_v[t] = 256; act_v[t] = 0; cmt_n[t] = 0;
    end
    repeat (3) @(negedge clk);
    check("reset valid", int'(o_valid), 0);
    check("reset mask", int'(o_lag_mask), 0);
    check("reset sel", int'(o_sel_id), 0);
    check("reset util", int'(o_utility), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R9: no active thread -> no strobe
    set_all(512, 0);
    evaluate("none_active");

    // R8 tie: identical threads -> lowest id
    set_all(512, 8);
    evaluate("tie_all");

    // R8 tie between threads 1 and 3, thread 0 weaker
    barrier(0);
    spd_v[0] = 300; spd_v[1] = 1024; spd_v[2] = 400; spd_v[3] = 1024;
    for (int t = 0; t < NT; t++) act_v[t] = 12;
    evaluate("tie_1_3");

    // R3 margin boundary: progress minP+3 lagging, minP+4 not
    barrier(0);
    cmt_n[0] = 10; cmt_n[1] = 13; cmt_n[2] = 14; cmt_n[3] = 20;
    commits();
    set_all(768, 16);
    evaluate("margin_edge");

    // R5: speedup at or below 1.0 gives zero utility
    spd_v[0] = 256; spd_v[1] = 100; spd_v[2] = 0; spd_v[3] = 200;
    evaluate("low_speedup");

    // R6: relevance saturation and inactive thread skipped
    barrier(0);
    spd_v[0] = 4096; spd_v[1] = 4096; spd_v[2] = 4096; spd_v[3] = 65535;
    act_v[0] = 0; act_v[1] = 16; act_v[2] = 200; act_v[3] = 15;
    evaluate("relevance");

    // R1 saturation: 300 and 260 commits both stop at the top value
    barrier(0);
    cmt_n[0] = 300; cmt_n[1] = 260; cmt_n[2] = 0; cmt_n[3] = 0;
    commits();
    set_all(1024, 0);
    act_v[0] = 10; act_v[1] = 5;
    evaluate("saturate");

    // R2: barrier with commits in the same cycle leaves all counters at zero
    cmt_n[0] = 0; cmt_n[1] = 0; cmt_n[2] = 6; cmt_n[3] = 6;
    commits();
    barrier(1);
    cmt_n[0] = 3; cmt_n[1] = 5; cmt_n[2] = 0; cmt_n[3] = 9;
    commits();
    set_all(640, 9);
    evaluate("barrier_commit");

    // R4: three lagging threads share the global factor
    barrier(0);
    cmt_n[0] = 1; cmt_n[1] = 2; cmt_n[2] = 3; cmt_n[3] = 40;
    commits();
    spd_v[0] = 512; spd_v[1] = 2048; spd_v[2] = 1024; spd_v[3] = 8192;
    for (int t = 0; t < NT; t++) act_v[t] = 7;
    evaluate("global_share");

    // R10: tick and input changes during a running evaluation
    barrier(0);
    cmt_n[0] = 5; cmt_n[1] = 2; cmt_n[2] = 4; cmt_n[3] = 2;
    commits();
    spd_v[0] = 900; spd_v[1] = 300; spd_v[2] = 2000; spd_v[3] = 700;
    act_v[0] = 3; act_v[1] = 14; act_v[2] = 6; act_v[3] = 9;
    compute_exp();
    @(negedge clk);
    drive_inputs();
    i_quantum_tick = 1'b1;
    @(negedge clk);
    i_quantum_tick = 1'b0;
    repeat (5) @(negedge clk);
    for (int t = 0; t < NT; t++) begin
      i_speedup[t] = 16'd4096;
      i_active_cyc[t] = AW'(16);
    end
    i_commit = 4'b0010;
    i_quantum_tick = 1'b1;
    if (mprog[1] < PMAX) mprog[1]++;
    @(negedge clk);
    i_commit = '0;
    i_quantum_tick = 1'b0;
    await_result("busy_tick R10");

    // pseudo-random sweep over progress, speedup and activity
    for (int it = 0; it < 30; it++) begin
      if (it % 3 == 0) barrier(0);
      for (int t = 0; t < NT; t++) begin
        lf = step(lf); cmt_n[t] = int'(lf[3:0]);
        lf = step(lf);
        case (lf[3:0] % 10)
          0: spd_v[t] = 0;
          1: spd_v[t] = 128;
          2: spd_v[t] = 256;
          3: spd_v[t] = 257;
          4: spd_v[t] = 300;
          5: spd_v[t] = 384;
          6: spd_v[t] = 512;
          7: spd_v[t] = 1024;
          8: spd_v[t] = 4096;
          default: spd_v[t] = 65535;
        endcase
        lf = step(lf); act_v[t] = int'(lf[7:0]) % 21;
      end
      commits();
      evaluate("sweep R1 R3 R4 R5 R6 R7 R8");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule